// File: doc/BRIEF.md
# Four-Way Write-Through Cache Controller with Per-Word Valid Bits

This block is a four-way set-associative cache controller for a 32-bit byte-addressed processor whose every access is a full 32-bit word. Each line holds eight words. For each way the block keeps a tag, a data array and one valid bit per word. A load is looked up in the same cycle that the request is accepted. The tags of all four ways in the selected set are compared at once. On a hit the word from the matching way is returned in the next cycle.

Each store is written through to memory. A store that misses claims a line in the way named by an external replacement unit, writes the new tag there and marks only the stored word valid. The rest of that line is not fetched. A load that misses, or that finds its tag but not a valid word, fetches the whole line from memory, marks all eight words valid and returns the requested word. After every hit and every fill, the block reports the way it touched so that the replacement unit can update its state.

Top module: `cache_wt_ctrl`

## Requirements
- R1: Address split: bits [1:0] are a byte offset, bits [4:2] select the word in the line, bits [11:5] select one of 128 sets and bits [31:12] are the 20-bit tag. The line fetch address carries the tag and set with bits [4:0] zero.
- R2: Reset clears every valid bit, so the first load to any address after reset fetches its line.
- R3: A load whose tag matches a way and whose word is valid in that way raises `cpu_rsp_valid` one cycle after acceptance. It returns that way's word and causes no memory traffic.
- R4: A load miss issues one line fetch and takes eight beats in ascending word order. It fills the way given on `victim_way` at acceptance and marks all eight words valid. The requested word is returned the cycle after the last beat. The fetch request and its address are held until they are accepted.
- R5: Tags of all ways in the set are compared in parallel; at most one way matches.
- R6: Every store, hit or miss, issues one memory write with the word-aligned address and the store data. The write is held until it is accepted. The CPU response (read data zero) follows one cycle after acceptance.
- R7: A store miss writes the new tag into the victim way and marks only the stored word valid. It fetches nothing. A later load of that word hits.
- R8: A load whose tag matches but whose word is invalid fetches the line into the matching way, not into the victim.
- R9: A store hit updates the word and sets its valid bit, and a later load returns the new value.
- R10: `way_upd_valid` pulses with `way_upd_idx`. For a load hit or a load fill the pulse comes with the response and names the way that hit or was filled. For a store it comes one cycle after acceptance and names the way that was written.
- R11: `cpu_req_ready` is high only when no fetch or write-through is outstanding. After reset it is high and all memory requests are low.
- R12: Byte-offset bits have no effect. An address with nonzero bits [1:0] behaves as the aligned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | Response pulse |
| cpu_rsp_rdata | output | 32 | Load data (zero for stores) |
| victim_way | input | 2 | Way to fill or claim on a miss |
| way_upd_valid | output | 1 | Way report pulse |
| way_upd_idx | output | 2 | Way that hit or was filled |
| mem_rd_req_valid | output | 1 | Line fetch request |
| mem_rd_req_ready | input | 1 | Fetch request accepted |
| mem_rd_req_addr | output | 32 | Line-aligned fetch address |
| mem_rd_beat_valid | input | 1 | Fetch data beat present |
| mem_rd_beat_data | input | 32 | Fetch data beat |
| mem_wr_valid | output | 1 | Write-through request |
| mem_wr_ready | input | 1 | Write accepted |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write data |

## Verification
The assertions check on every cycle that at most one way matches the looked-up tag. They also check that fetch and write requests hold their address and data until accepted, that the controller never offers ready while memory work is outstanding, and that an accepted request either responds in the next cycle or drops ready. The bench scenarios show the rest against a reference model of tags and word valids. That covers returned data, the way that was filled or reported, fetch and write counts and addresses, hit latency, partial lines left by store misses, evictions under set conflict, and the byte-offset bits being ignored.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FILL_REQ  = 2'd1,
        ST_FILL_DATA = 2'd2,
        ST_WR_MEM    = 2'd3
    } ctrl_state_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int TAG_W      = 20,
    parameter int LINE_WORDS = 8,
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [SET_W-1:0]                      rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]            rd_tag,
    output logic [WAYS-1:0][LINE_WORDS-1:0]       rd_vld,
    input  logic                                  wr_en,
    input  logic [WAY_W-1:0]                      wr_way,
    input  logic [SET_W-1:0]                      wr_set,
    input  logic [TAG_W-1:0]                      wr_tag,
    input  logic [LINE_WORDS-1:0]                 wr_vld
);

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [TAG_W-1:0]      tag_mem [SETS];
        logic [LINE_WORDS-1:0] vld_mem [SETS];
        logic                  sel;

        assign sel = wr_en && (wr_way == WAY_W'(g));

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_mem[wr_set] <= wr_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    vld_mem[s] <= '0;
                end
            end else if (sel) begin
                vld_mem[wr_set] <= wr_vld;
            end
        end

        assign rd_tag[g] = tag_mem[rd_set];
        assign rd_vld[g] = vld_mem[rd_set];
    end

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 8,
    parameter int DATA_W     = 32,
    localparam int SET_W     = $clog2(SETS),
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int DEPTH     = SETS * LINE_WORDS
) (
    input  logic                           clk,
    input  logic [SET_W-1:0]               rd_set,
    input  logic [OFF_W-1:0]               rd_word,
    output logic [WAYS-1:0][DATA_W-1:0]    rd_data,
    input  logic                           wr_en,
    input  logic [WAY_W-1:0]               wr_way,
    input  logic [SET_W-1:0]               wr_set,
    input  logic [OFF_W-1:0]               wr_word,
    input  logic [DATA_W-1:0]              wr_data
);

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == WAY_W'(g))) begin
                mem[{wr_set, wr_word}] <= wr_data;
            end
        end

        assign rd_data[g] = mem[{rd_set, rd_word}];
    end

endmodule

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
    parameter int WAYS       = 4,
    parameter int TAG_W      = 20,
    parameter int LINE_WORDS = 8,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
    input  logic [WAYS-1:0][LINE_WORDS-1:0]  rd_vld,
    input  logic [TAG_W-1:0]                 lk_tag,
    input  logic [OFF_W-1:0]                 lk_word,
    output logic [WAYS-1:0]                  match_vec,
    output logic                             match_any,
    output logic [WAY_W-1:0]                 match_way,
    output logic                             word_hit
);

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match_vec[g] = (rd_tag[g] == lk_tag) && (|rd_vld[g]);
    end

    always_comb begin
        match_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match_vec[i]) begin
                match_way = WAY_W'(i);
            end
        end
    end

    assign match_any = |match_vec;
    assign word_hit  = match_any && rd_vld[match_way][lk_word];

endmodule

// File: rtl/cache_wt_ctrl.sv
module cache_wt_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 8,
    localparam int WAY_W     = $clog2(WAYS),
    localparam int SET_W     = $clog2(SETS),
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int BYTE_W    = $clog2(DATA_W / 8),
    localparam int WADDR_W   = ADDR_W - BYTE_W,
    localparam int TAG_W     = ADDR_W - SET_W - OFF_W - BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req_valid,
    output logic               cpu_req_ready,
    input  logic               cpu_req_we,
    input  logic [ADDR_W-1:0]  cpu_req_addr,
    input  logic [DATA_W-1:0]  cpu_req_wdata,
    output logic               cpu_rsp_valid,
    output logic [DATA_W-1:0]  cpu_rsp_rdata,
    input  logic [WAY_W-1:0]   victim_way,
    output logic               way_upd_valid,
    output logic [WAY_W-1:0]   way_upd_idx,
    output logic               mem_rd_req_valid,
    input  logic               mem_rd_req_ready,
    output logic [ADDR_W-1:0]  mem_rd_req_addr,
    input  logic               mem_rd_beat_valid,
    input  logic [DATA_W-1:0]  mem_rd_beat_data,
    output logic               mem_wr_valid,
    input  logic               mem_wr_ready,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [DATA_W-1:0]  mem_wr_data
);

    typedef struct packed {
        ctrl_state_e        st;
        logic [WADDR_W-1:0] addr;
        logic [DATA_W-1:0]  wdata;
        logic [WAY_W-1:0]   way;
        logic [OFF_W-1:0]   beat;
        logic [DATA_W-1:0]  word;
        logic               rsp_valid;
        logic [DATA_W-1:0]  rsp_data;
        logic               upd_valid;
        logic [WAY_W-1:0]   upd_way;
    } ctrl_regs_t;

    ctrl_regs_t regs_d, regs_q;

    // Address fields of the incoming request (looked up in the accept cycle)
    logic [OFF_W-1:0] lk_word;
    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic             unused_byte_bits;

    assign lk_word          = cpu_req_addr[BYTE_W +: OFF_W];
    assign lk_set           = cpu_req_addr[BYTE_W + OFF_W +: SET_W];
    assign lk_tag           = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign unused_byte_bits = ^cpu_req_addr[BYTE_W-1:0];

    // Address fields of the held request
    logic [OFF_W-1:0] hq_word;
    logic [SET_W-1:0] hq_set;
    logic [TAG_W-1:0] hq_tag;

    assign hq_word = regs_q.addr[0 +: OFF_W];
    assign hq_set  = regs_q.addr[OFF_W +: SET_W];
    assign hq_tag  = regs_q.addr[WADDR_W-1 -: TAG_W];

    // Storage and compare
    logic [WAYS-1:0][TAG_W-1:0]      rd_tag;
    logic [WAYS-1:0][LINE_WORDS-1:0] rd_vld;
    logic [WAYS-1:0][DATA_W-1:0]     rd_data;
    logic [WAYS-1:0]                 match_vec;
    logic                            match_any;
    logic [WAY_W-1:0]                match_way;
    logic                            word_hit;

    logic                  tag_we;
    logic [WAY_W-1:0]      tag_wr_way;
    logic [SET_W-1:0]      tag_wr_set;
    logic [TAG_W-1:0]      tag_wr_tag;
    logic [LINE_WORDS-1:0] tag_wr_vld;

    logic                  dat_we;
    logic [WAY_W-1:0]      dat_wr_way;
    logic [SET_W-1:0]      dat_wr_set;
    logic [OFF_W-1:0]      dat_wr_word;
    logic [DATA_W-1:0]     dat_wr_data;

    logic [LINE_WORDS-1:0] word_bit;
    assign word_bit = {{(LINE_WORDS-1){1'b0}}, 1'b1} << lk_word;

    cache_tag_store #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .LINE_WORDS(LINE_WORDS)
    ) i_tag_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_set (lk_set),
        .rd_tag (rd_tag),
        .rd_vld (rd_vld),
        .wr_en  (tag_we),
        .wr_way (tag_wr_way),
        .wr_set (tag_wr_set),
        .wr_tag (tag_wr_tag),
        .wr_vld (tag_wr_vld)
    );

    cache_data_store #(
        .WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)
    ) i_data_store (
        .clk     (clk),
        .rd_set  (lk_set),
        .rd_word (lk_word),
        .rd_data (rd_data),
        .wr_en   (dat_we),
        .wr_way  (dat_wr_way),
        .wr_set  (dat_wr_set),
        .wr_word (dat_wr_word),
        .wr_data (dat_wr_data)
    );

    cache_tag_match #(
        .WAYS(WAYS), .TAG_W(TAG_W), .LINE_WORDS(LINE_WORDS)
    ) i_tag_match (
        .rd_tag    (rd_tag),
        .rd_vld    (rd_vld),
        .lk_tag    (lk_tag),
        .lk_word   (lk_word),
        .match_vec (match_vec),
        .match_any (match_any),
        .match_way (match_way),
        .word_hit  (word_hit)
    );

    // Next-state logic
    always_comb begin
        logic [WAY_W-1:0] sel_way;

        regs_d           = regs_q;
        regs_d.rsp_valid = 1'b0;
        regs_d.upd_valid = 1'b0;

        sel_way     = match_any ? match_way : victim_way;

        tag_we      = 1'b0;
        tag_wr_way  = regs_q.way;
        tag_wr_set  = hq_set;
        tag_wr_tag  = hq_tag;
        tag_wr_vld  = '1;

        dat_we      = 1'b0;
        dat_wr_way  = regs_q.way;
        dat_wr_set  = hq_set;
        dat_wr_word = regs_q.beat;
        dat_wr_data = mem_rd_beat_data;

        unique case (regs_q.st)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    regs_d.addr  = cpu_req_addr[ADDR_W-1:BYTE_W];
                    regs_d.wdata = cpu_req_wdata;
                    regs_d.way   = sel_way;
                    regs_d.beat  = '0;
                    if (cpu_req_we) begin
                        // store: update or claim a line, then write through
                        regs_d.st        = ST_WR_MEM;
                        regs_d.upd_valid = 1'b1;
                        regs_d.upd_way   = sel_way;
                        tag_we           = 1'b1;
                        tag_wr_way       = sel_way;
                        tag_wr_set       = lk_set;
                        tag_wr_tag       = lk_tag;
                        tag_wr_vld       = match_any ? (rd_vld[match_way] | word_bit)
                                                     : word_bit;
                        dat_we           = 1'b1;
                        dat_wr_way       = sel_way;
                        dat_wr_set       = lk_set;
                        dat_wr_word      = lk_word;
                        dat_wr_data      = cpu_req_wdata;
                    end else if (word_hit) begin
                        regs_d.rsp_valid = 1'b1;
                        regs_d.rsp_data  = rd_data[match_way];
                        regs_d.upd_valid = 1'b1;
                        regs_d.upd_way   = match_way;
                    end else begin
                        regs_d.st = ST_FILL_REQ;
                    end
                end
            end

            ST_FILL_REQ: begin
                if (mem_rd_req_ready) begin
                    regs_d.st = ST_FILL_DATA;
                end
            end

            ST_FILL_DATA: begin
                if (mem_rd_beat_valid) begin
                    dat_we      = 1'b1;
                    regs_d.beat = regs_q.beat + 1'b1;
                    if (regs_q.beat == hq_word) begin
                        regs_d.word = mem_rd_beat_data;
                    end
                    if (regs_q.beat == OFF_W'(LINE_WORDS - 1)) begin
                        tag_we           = 1'b1;
                        regs_d.st        = ST_IDLE;
                        regs_d.rsp_valid = 1'b1;
                        regs_d.rsp_data  = (regs_q.beat == hq_word) ? mem_rd_beat_data
                                                                    : regs_q.word;
                        regs_d.upd_valid = 1'b1;
                        regs_d.upd_way   = regs_q.way;
                    end
                end
            end

            ST_WR_MEM: begin
                if (mem_wr_ready) begin
                    regs_d.st        = ST_IDLE;
                    regs_d.rsp_valid = 1'b1;
                    regs_d.rsp_data  = '0;
                end
            end

            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Outputs
    assign cpu_req_ready    = (regs_q.st == ST_IDLE);
    assign cpu_rsp_valid    = regs_q.rsp_valid;
    assign cpu_rsp_rdata    = regs_q.rsp_data;
    assign way_upd_valid    = regs_q.upd_valid;
    assign way_upd_idx      = regs_q.upd_way;
    assign mem_rd_req_valid = (regs_q.st == ST_FILL_REQ);
    assign mem_rd_req_addr  = {regs_q.addr[WADDR_W-1:OFF_W], {(OFF_W + BYTE_W){1'b0}}};
    assign mem_wr_valid     = (regs_q.st == ST_WR_MEM);
    assign mem_wr_addr      = {regs_q.addr, {BYTE_W{1'b0}}};
    assign mem_wr_data      = regs_q.wdata;

    // Assertions
    AST_SINGLE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_IDLE) |-> $onehot0(match_vec)); // R5

    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req_valid && !mem_rd_req_ready) |=>
            (mem_rd_req_valid && $stable(mem_rd_req_addr))); // R4

    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R6

    AST_ACCEPT_THEN_RSP_OR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> (cpu_rsp_valid || !cpu_req_ready)); // R3

    AST_NO_READY_WHILE_MEM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req_valid || mem_wr_valid) |-> !cpu_req_ready); // R11

endmodule

// File: tb/test_cache_wt_ctrl.sv
module test_cache_wt_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        cpu_req_valid;
    logic        cpu_req_ready;
    logic        cpu_req_we;
    logic [31:0] cpu_req_addr;
    logic [31:0] cpu_req_wdata;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic [1:0]  victim_way;
    logic        way_upd_valid;
    logic [1:0]  way_upd_idx;
    logic        mem_rd_req_valid;
    logic        mem_rd_req_ready;
    logic [31:0] mem_rd_req_addr;
    logic        mem_rd_beat_valid;
    logic [31:0] mem_rd_beat_data;
    logic        mem_wr_valid;
    logic        mem_wr_ready;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;

    cache_wt_ctrl i_cache_wt_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .cpu_req_valid     (cpu_req_valid),
        .cpu_req_ready     (cpu_req_ready),
        .cpu_req_we        (cpu_req_we),
        .cpu_req_addr      (cpu_req_addr),
        .cpu_req_wdata     (cpu_req_wdata),
        .cpu_rsp_valid     (cpu_rsp_valid),
        .cpu_rsp_rdata     (cpu_rsp_rdata),
        .victim_way        (victim_way),
        .way_upd_valid     (way_upd_valid),
        .way_upd_idx       (way_upd_idx),
        .mem_rd_req_valid  (mem_rd_req_valid),
        .mem_rd_req_ready  (mem_rd_req_ready),
        .mem_rd_req_addr   (mem_rd_req_addr),
        .mem_rd_beat_valid (mem_rd_beat_valid),
        .mem_rd_beat_data  (mem_rd_beat_data),
        .mem_wr_valid      (mem_wr_valid),
        .mem_wr_ready      (mem_wr_ready),
        .mem_wr_addr       (mem_wr_addr),
        .mem_wr_data       (mem_wr_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] bmem [int unsigned];

    function automatic logic [31:0] memval(input logic [31:0] a);
        int unsigned key = int'(a >> 2);
        if (bmem.exists(key)) return bmem[key];
        return (32'(a[31:2]) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    int          fetch_cnt = 0;
    logic [31:0] last_fetch = '0;
    int          wr_cnt = 0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;

    initial begin
        int          beats_left = 0;
        int          beat_idx   = 0;
        logic [31:0] line       = '0;
        mem_rd_req_ready  = 1'b0;
        mem_rd_beat_valid = 1'b0;
        mem_rd_beat_data  = '0;
        mem_wr_ready      = 1'b0;
        forever begin
            @(negedge clk);
            mem_rd_req_ready  = 1'b0;
            mem_rd_beat_valid = 1'b0;
            mem_wr_ready      = 1'b0;
            if (beats_left > 0) begin
                if (($urandom % 4) != 0) begin
                    mem_rd_beat_valid = 1'b1;
                    mem_rd_beat_data  = memval(line + 32'(beat_idx * 4));
                    beat_idx++;
                    beats_left--;
                end
            end else if (rst_n && mem_rd_req_valid && (($urandom % 3) != 0)) begin
                mem_rd_req_ready = 1'b1;
                fetch_cnt++;
                last_fetch = mem_rd_req_addr;
                line       = mem_rd_req_addr;
                beat_idx   = 0;
                beats_left = 8;
            end
            if (rst_n && mem_wr_valid && (($urandom % 3) != 0)) begin
                mem_wr_ready = 1'b1;
                wr_cnt++;
                last_wr_addr = mem_wr_addr;
                last_wr_data = mem_wr_data;
                bmem[int'(mem_wr_addr >> 2)] = mem_wr_data;
            end
        end
    end

    // ---------------- reference tag/valid model ----------------
    logic [19:0] rtag [4][128];
    logic [7:0]  rvld [4][128];

    function automatic logic [31:0] mkaddr(input logic [19:0] t, input logic [6:0] s,
                                           input logic [2:0] w, input logic [1:0] b);
        return {t, s, w, b};
    endfunction

    task automatic do_req(input logic we, input logic [31:0] addr,
                          input logic [31:0] wdata, input logic [1:0] vict,
                          input string req);
        logic [6:0]  s = addr[11:5];
        logic [19:0] t = addr[31:12];
        logic [2:0]  w = addr[4:2];
        int          mway = -1;
        logic        hit;
        logic [1:0]  exp_way;
        logic [31:0] exp_data;
        int          f0 = fetch_cnt;
        int          w0 = wr_cnt;
        int          lat;
        logic        got_upd = 1'b0;
        logic [1:0]  upd_way = '0;
        logic        timed_out = 1'b0;

        for (int i = 0; i < 4; i++) begin
            if (rtag[i][s] == t && rvld[i][s] != 8'h00) mway = i;
        end
        hit      = (mway >= 0) && rvld[mway][s][w];
        exp_way  = (mway >= 0) ? 2'(mway) : vict;
        exp_data = we ? 32'h0 : memval(addr);
        if (we) begin
            if (mway >= 0) rvld[exp_way][s] = rvld[exp_way][s] | (8'h01 << w);
            else begin
                rtag[exp_way][s] = t;
                rvld[exp_way][s] = 8'h01 << w;
            end
        end else if (!hit) begin
            rtag[exp_way][s] = t;
            rvld[exp_way][s] = 8'hFF;
        end

        cpu_req_valid = 1'b1;
        cpu_req_we    = we;
        cpu_req_addr  = addr;
        cpu_req_wdata = wdata;
        victim_way    = vict;
        lat = 0;
        while (!cpu_req_ready && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        victim_way    = 2'($urandom);
        lat = 1;
        forever begin
            if (way_upd_valid) begin
                got_upd = 1'b1;
                upd_way = way_upd_idx;
            end
            if (cpu_rsp_valid) break;
            if (lat > 1000) begin
                timed_out = 1'b1;
                break;
            end
            @(negedge clk);
            lat++;
        end

        check(req, "response seen", {31'b0, !timed_out}, 32'h1);
        check(req, "R10 way report", {29'b0, got_upd, upd_way}, {29'b0, 1'b1, exp_way});
        if (we) begin
            check(req, "R6 write count", 32'(wr_cnt - w0), 32'h1);
            check(req, "R6 write addr", last_wr_addr, {addr[31:2], 2'b00});
            check(req, "R6 write data", last_wr_data, wdata);
            check(req, "R7 store makes no fetch", 32'(fetch_cnt - f0), 32'h0);
            check(req, "R6 store rsp data", cpu_rsp_rdata, 32'h0);
        end else begin
            check(req, "R3/R4 read data", cpu_rsp_rdata, exp_data);
            check(req, "R4 fetch count", 32'(fetch_cnt - f0), hit ? 32'h0 : 32'h1);
            check(req, "R11 no write on load", 32'(wr_cnt - w0), 32'h0);
            if (hit) check(req, "R3 hit latency", 32'(lat), 32'h1);
            else     check(req, "R1 fetch line addr", last_fetch, {t, s, 5'b0});
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    logic [19:0] tag_pool [6];
    logic [6:0]  set_pool [3];

    initial begin
        logic [31:0] a_addr;
        logic [31:0] b_addr;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++)
            for (int s = 0; s < 128; s++) begin
                rtag[i][s] = '0;
                rvld[i][s] = '0;
            end
        tag_pool = '{20'h00012, 20'h00013, 20'h3FF00, 20'h00000, 20'hABCDE, 20'h00777};
        set_pool = '{7'd5, 7'd6, 7'd127};

        rst_n         = 1'b0;
        cpu_req_valid = 1'b0;
        cpu_req_we    = 1'b0;
        cpu_req_addr  = '0;
        cpu_req_wdata = '0;
        victim_way    = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R11", "ready after reset", {31'b0, cpu_req_ready}, 32'h1);
        check("R11", "rsp after reset", {31'b0, cpu_rsp_valid}, 32'h0);
        check("R11", "fetch req after reset", {31'b0, mem_rd_req_valid}, 32'h0);
        check("R11", "write req after reset", {31'b0, mem_wr_valid}, 32'h0);

        a_addr = mkaddr(20'h00012, 7'd5, 3'd1, 2'd0);
        b_addr = mkaddr(20'h3FF00, 7'd6, 3'd3, 2'd0);

        do_req(1'b0, a_addr, '0, 2'd2, "R2 first load misses");
        do_req(1'b0, a_addr + 32'd4, '0, 2'd0, "R3 same-line hit");
        do_req(1'b1, b_addr, 32'hCAFE_0001, 2'd1, "R7 store miss claim");
        do_req(1'b0, b_addr, '0, 2'd3, "R7 load stored word");
        do_req(1'b0, b_addr + 32'd8, '0, 2'd3, "R8 partial line fill");
        do_req(1'b1, a_addr, 32'h1234_5678, 2'd3, "R9 store hit");
        do_req(1'b0, a_addr, '0, 2'd0, "R9 load after store");
        do_req(1'b0, a_addr | 32'd3, '0, 2'd1, "R12 byte offset load");
        do_req(1'b1, mkaddr(20'h00012, 7'd5, 3'd7, 2'd2), 32'h0BAD_F00D, 2'd0, "R12 byte offset store");
        do_req(1'b0, mkaddr(20'h00012, 7'd5, 3'd7, 2'd0), '0, 2'd0, "R12 aligned readback");

        for (int k = 0; k < 5; k++)
            do_req(1'b0, mkaddr(20'h00100 + 20'(k), 7'd9, 3'(k), 2'd0), '0, 2'(k), "R5 set conflict");
        do_req(1'b0, mkaddr(20'h00100, 7'd9, 3'd2, 2'd0), '0, 2'd3, "R5 evicted tag refetch");

        for (int n = 0; n < 600; n++) begin
            logic [31:0] ra = mkaddr(tag_pool[$urandom % 6], set_pool[$urandom % 3],
                                     3'($urandom), 2'($urandom));
            logic        rw = (($urandom % 10) < 4);
            do_req(rw, ra, $urandom, 2'($urandom), rw ? "R6 random store" : "R4 random load");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule